// File: doc/BRIEF.md
# Timer Tick Prescaler and Input Glitch Filter

This block is the front end of a low-power counter. It takes four clock-enable strobes that all belong to one clock domain and picks one of them. In time-count mode it divides the chosen strobe by a power of two and issues a one-cycle tick for every completed period. In pulse-count mode it uses the chosen strobe to sample a synchronised external input. The input is accepted only after it has stayed at a new level for a power-of-two number of strobes. A single 4-bit scale setting serves both roles: it sets the divide ratio in one mode and the filter length in the other.

A bypass bit turns off both functions. With bypass set, every selected strobe becomes a tick, or the synchronised input goes straight to the level output. While the run input is low, all divider and filter state is held cleared, so each new run starts from a fresh count.

The configuration word has this layout: bits [1:0] select the strobe source, bit [2] is the bypass control, and bits [6:3] hold the scale value S.

Top module: `lptf_front`

## Requirements
- R1: Field cfg_word[1:0] picks which of the four src_en bits advances the divider and the filter. The other three strobes have no effect.
- R2: In time-count mode (mode_pulse=0) with bypass clear, tick_o pulses high for one cycle per 2^(S+1) selected strobes. The pulse appears the cycle after the strobe that completes the period.
- R3: In time-count mode with bypass set (cfg_word[2]=1), tick_o is high in the cycle after each selected strobe.
- R4: In pulse-count mode with bypass clear, level_o takes a new synchronised input value only after 2^S consecutive selected strobes during which that value differed from level_o. If the input returns to the level_o value first, the count restarts.
- R5: With S=0 in pulse-count mode, level_o follows the synchronised input at the first selected strobe that sees the difference.
- R6: In pulse-count mode with bypass set, level_o equals pulse_in delayed by two clock cycles.
- R7: While run is 0, tick_o and level_o are 0 and divider and filter state is cleared. After run rises, the first tick needs a full new period.
- R8: tick_o is never high in pulse-count mode, and level_o is 0 in time-count mode.
- R9: If S is lowered while the divider count is already at or above the new period end, the next selected strobe produces a tick.
- R10: While rst_n is low, tick_o and level_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the parent |
| src_en | input | 4 | Four candidate clock-enable strobes |
| pulse_in | input | 1 | Raw external pulse input, asynchronous |
| run | input | 1 | Timer enable; 0 clears divider and filter state |
| mode_pulse | input | 1 | 0 selects time-count mode, 1 selects pulse-count mode |
| cfg_word | input | 7 | Source select [1:0], bypass [2], scale S [6:3] |
| tick_o | output | 1 | One-cycle counter tick |
| level_o | output | 1 | Filtered (or bypassed) input level |

## Verification
Some properties are checked on every cycle:
- A tick can only follow a cycle that had an active selected strobe.
- Pulse mode never ticks.
- Idle divider and filter state stays cleared.
- The filtered level holds between strobes and only ever moves to the synchronised input value.

Other behaviour can only be shown by the bench scenarios:
- Exact tick counts for each divide ratio and source.
- Rejection of a glitch one strobe shorter than the filter length, and the cycle at which a held input is accepted.
- The two-cycle bypass latency.
- The early tick after the scale is lowered mid-count.

// File: rtl/lptf_pkg.sv
package lptf_pkg;

  typedef enum logic {
    MODE_TIME  = 1'b0,
    MODE_PULSE = 1'b1
  } cnt_mode_e;

endpackage

// File: rtl/lptf_sync.sv
module lptf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/lptf_div.sv
module lptf_div #(
  parameter  int SCALE_W = 4,
  localparam int DIV_W   = 1 << SCALE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               bypass,
  input  logic               sel_en,
  input  logic [SCALE_W-1:0] scale,
  output logic               tick_o
);

  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] lim;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;

  // period end = 2^(scale+1) - 1
  always_comb begin
    span = (DIV_W+1)'(2) << scale;
    lim  = span[DIV_W-1:0] - DIV_W'(1);
  end

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (!active || bypass) begin
      cnt_d  = '0;
      tick_d = active && bypass && sel_en;
    end else if (sel_en) begin
      if (cnt_q >= lim) begin
        cnt_d  = '0;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  // R2
  tick_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(active && sel_en) |=> !tick_q);

  // R7
  div_idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt_q == '0) && !tick_q);

endmodule

// File: rtl/lptf_filt.sv
module lptf_filt #(
  parameter  int SCALE_W = 4,
  localparam int FILT_W  = (1 << SCALE_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               sel_en,
  input  logic [SCALE_W-1:0] scale,
  input  logic               din,
  output logic               level_o
);

  logic [FILT_W:0]   span;
  logic [FILT_W-1:0] thr;
  logic [FILT_W-1:0] stab_q, stab_d;
  logic              filt_q, filt_d;

  // acceptance point = 2^scale - 1 (scale 0 gives a single sample)
  always_comb begin
    span = (FILT_W+1)'(1) << scale;
    thr  = span[FILT_W-1:0] - FILT_W'(1);
  end

  always_comb begin
    filt_d = filt_q;
    stab_d = stab_q;
    if (!active) begin
      filt_d = 1'b0;
      stab_d = '0;
    end else if (din == filt_q) begin
      stab_d = '0;
    end else if (sel_en) begin
      if (stab_q >= thr) begin
        filt_d = din;
        stab_d = '0;
      end else begin
        stab_d = stab_q + FILT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      stab_q <= '0;
    end else begin
      filt_q <= filt_d;
      stab_q <= stab_d;
    end
  end

  assign level_o = filt_q;

  // R4
  filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sel_en) |=> $stable(filt_q));

  // R4
  filt_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (filt_q == $past(filt_q)) || (filt_q == $past(din)));

  // R7
  filt_idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !filt_q && (stab_q == '0));

endmodule

// File: rtl/lptf_front.sv
module lptf_front
  import lptf_pkg::*;
#(
  parameter  int NSRC        = 4,
  parameter  int SCALE_W     = 4,
  parameter  int SYNC_STAGES = 2,
  localparam int SEL_W       = $clog2(NSRC),
  localparam int CFG_W       = SEL_W + 1 + SCALE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_en,
  input  logic             pulse_in,
  input  logic             run,
  input  logic             mode_pulse,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             tick_o,
  output logic             level_o
);

  cnt_mode_e          mode;
  logic [SEL_W-1:0]   sel;
  logic               byp;
  logic [SCALE_W-1:0] scale;
  logic               sel_en;
  logic               sync_q;
  logic               filt_lvl;
  logic               div_act;
  logic               filt_act;

  always_comb begin
    mode     = cnt_mode_e'(mode_pulse);
    sel      = cfg_word[SEL_W-1:0];
    byp      = cfg_word[SEL_W];
    scale    = cfg_word[CFG_W-1:SEL_W+1];
    sel_en   = src_en[sel];
    div_act  = run && (mode == MODE_TIME);
    filt_act = run && (mode == MODE_PULSE) && !byp;
  end

  lptf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pulse_in),
    .q_o   (sync_q)
  );

  lptf_div #(.SCALE_W(SCALE_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (div_act),
    .bypass (byp),
    .sel_en (sel_en),
    .scale  (scale),
    .tick_o (tick_o)
  );

  lptf_filt #(.SCALE_W(SCALE_W)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (filt_act),
    .sel_en  (sel_en),
    .scale   (scale),
    .din     (sync_q),
    .level_o (filt_lvl)
  );

  always_comb begin
    if (run && (mode == MODE_PULSE)) begin
      level_o = byp ? sync_q : filt_lvl;
    end else begin
      level_o = 1'b0;
    end
  end

  // R8
  pulse_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PULSE) |=> !tick_o);

  // R10
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!tick_o && !filt_lvl);
    end
  end

endmodule

// File: tb/lptf_front_tb.sv
module lptf_front_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] src_en = 4'b0000;
  logic       pulse_in;
  logic       run;
  logic       mode_pulse;
  logic [6:0] cfg_word;
  logic       tick_o;
  logic       level_o;

  always #2 clk = ~clk;

  lptf_front u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_en     (src_en),
    .pulse_in   (pulse_in),
    .run        (run),
    .mode_pulse (mode_pulse),
    .cfg_word   (cfg_word),
    .tick_o     (tick_o),
    .level_o    (level_o)
  );

  int    n_chk   = 0;
  int    n_fail  = 0;
  bit    started = 1'b0;
  bit    done    = 1'b0;
  string cur_req = "R10";

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d @%0t", req, what, act, exp, $time);
    end
  endtask

  // strobe sources with periods 1, 2, 3 and 5 cycles
  int cyc = 0;
  always @(negedge clk) begin
    cyc    <= cyc + 1;
    src_en <= {(cyc % 5) == 0, (cyc % 3) == 0, (cyc % 2) == 0, 1'b1};
  end

  // behavioural reference model
  bit m_s1, m_s2, m_filt, m_tick;
  int m_div, m_stab;
  always @(posedge clk) begin
    int  s, lim, thr;
    bit  en, byp;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_filt = 0; m_tick = 0; m_div = 0; m_stab = 0;
    end else begin
      s   = int'(cfg_word[6:3]);
      lim = (1 << (s + 1)) - 1;
      thr = (1 << s) - 1;
      en  = src_en[cfg_word[1:0]];
      byp = cfg_word[2];
      m_tick = 0;
      if (!run || mode_pulse) begin
        m_div = 0;
      end else if (byp) begin
        m_div  = 0;
        m_tick = en;
      end else if (en) begin
        if (m_div >= lim) begin m_div = 0; m_tick = 1; end
        else m_div++;
      end
      if (!run || !mode_pulse || byp) begin
        m_filt = 0; m_stab = 0;
      end else if (m_s2 == m_filt) begin
        m_stab = 0;
      end else if (en) begin
        if (m_stab >= thr) begin m_filt = m_s2; m_stab = 0; end
        else m_stab++;
      end
      m_s2 = m_s1;
      m_s1 = pulse_in;
    end
  end

  always @(posedge clk) begin
    int exp_lvl;
    #1;
    if (rst_n && started && !done) begin
      exp_lvl = (run && mode_pulse) ? (cfg_word[2] ? int'(m_s2) : int'(m_filt)) : 0;
      check(cur_req, int'(tick_o), int'(m_tick), "model tick");
      check(cur_req, int'(level_o), exp_lvl, "model level");
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_cfg(int sel, int byp, int scale);
    cfg_word = {4'(scale), 1'(byp), 2'(sel)};
  endtask

  task automatic count_ticks(int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      step();
      if (tick_o) n++;
    end
  endtask

  task automatic restart_run();
    run = 1'b0;
    step();
    run = 1'b1;
  endtask

  initial begin
    int n;
    rst_n = 1'b0; run = 1'b0; mode_pulse = 1'b0; pulse_in = 1'b0;
    cfg_word = '0;
    repeat (3) step();
    check("R10", int'(tick_o), 0, "tick in reset");
    check("R10", int'(level_o), 0, "level in reset");
    rst_n = 1'b1;
    started = 1'b1;

    // R2: divide by 8 on the every-cycle source; R8 level stays 0 in time mode
    cur_req = "R2"; pulse_in = 1'b1;
    set_cfg(0, 0, 2); restart_run();
    count_ticks(40, n);
    check("R2", n, 5, "ticks /8 over 40 strobes");
    check("R8", int'(level_o), 0, "level in time mode");

    // R2: divide by 2 on the period-2 source
    set_cfg(1, 0, 0); restart_run();
    count_ticks(40, n);
    check("R2", n, 10, "ticks /2 over 20 strobes");

    // R1 / R3: bypass, each source gives its own strobe count
    cur_req = "R3";
    set_cfg(2, 1, 0); restart_run();
    count_ticks(30, n);
    check("R1", n, 10, "bypass ticks source 2");
    set_cfg(3, 1, 0); restart_run();
    count_ticks(30, n);
    check("R1", n, 6, "bypass ticks source 3");
    set_cfg(1, 1, 0); restart_run();
    count_ticks(30, n);
    check("R3", n, 15, "bypass ticks source 1");

    // R9: lower the scale in the middle of a long period
    cur_req = "R9";
    set_cfg(0, 0, 4); restart_run();
    count_ticks(20, n);
    check("R9", n, 0, "no tick before period end");
    set_cfg(0, 0, 1);
    step();
    check("R9", int'(tick_o), 1, "early tick after scale drop");
    step();
    check("R9", int'(tick_o), 0, "tick is one cycle");

    // R7: run low blanks outputs; fresh count afterwards
    cur_req = "R7";
    run = 1'b0; mode_pulse = 1'b1; set_cfg(0, 1, 0); pulse_in = 1'b1;
    repeat (3) begin
      step();
      check("R7", int'(level_o), 0, "level with run low");
      check("R7", int'(tick_o), 0, "tick with run low");
    end
    mode_pulse = 1'b0; set_cfg(0, 0, 0); run = 1'b1;
    step();
    check("R7", int'(tick_o), 0, "first strobe after run");
    step();
    check("R7", int'(tick_o), 1, "second strobe after run");

    // R4: glitch of 3 strobes rejected with filter length 4
    cur_req = "R4";
    run = 1'b0; pulse_in = 1'b0; mode_pulse = 1'b1; set_cfg(0, 0, 2);
    step(); run = 1'b1;
    repeat (4) step();
    pulse_in = 1'b1;
    repeat (3) step();
    pulse_in = 1'b0;
    for (int i = 0; i < 8; i++) begin
      step();
      check("R4", int'(level_o), 0, "glitch rejected");
      check("R8", int'(tick_o), 0, "no tick in pulse mode");
    end
    pulse_in = 1'b1;
    repeat (5) step();
    check("R4", int'(level_o), 0, "level before 4th strobe");
    step();
    check("R4", int'(level_o), 1, "level after 4th strobe");

    // R5: single-sample filter
    cur_req = "R5";
    set_cfg(0, 0, 0); pulse_in = 1'b0;
    repeat (2) step();
    check("R5", int'(level_o), 1, "level before sync delay");
    step();
    check("R5", int'(level_o), 0, "level one strobe after sync");

    // R6: bypass gives two-cycle latency
    cur_req = "R6";
    set_cfg(0, 1, 0); pulse_in = 1'b1;
    step();
    check("R6", int'(level_o), 0, "bypass after 1 cycle");
    step();
    check("R6", int'(level_o), 1, "bypass after 2 cycles");
    pulse_in = 1'b0;
    step();
    check("R6", int'(level_o), 1, "bypass fall after 1 cycle");
    step();
    check("R6", int'(level_o), 0, "bypass fall after 2 cycles");

    // R4 / R1: slow source, filter length 2, irregular input, model compare
    cur_req = "R4";
    set_cfg(3, 0, 1);
    for (int i = 0; i < 150; i++) begin
      pulse_in = ((i * 7) % 23) < 11;
      step();
    end
    cur_req = "R2";
    mode_pulse = 1'b0; set_cfg(2, 0, 1);
    repeat (100) step();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule